// File: doc/BRIEF.md
# Residue-Selector Function Cell

This block is a configurable logic cell that can realise any Boolean function of `NumIn` variables while using a selector with only `2^(NumIn-1)` data legs. The upper `NumIn-1` variables form the select index. The lowest variable is the residual one. It is not used for selection. Instead it feeds every leg, and each leg turns it into one of four residue values.

The four residue values are constant zero, constant one, the residual variable itself, and its inverse. A two-bit code per leg chooses among them. Between them these values cover every possible pair of truth-table rows that share the same select index.

The codes live in a configuration register. That register is loaded through a synchronous write port and cleared by a synchronous reset. The output path is purely combinational from the variable inputs and the stored codes. A system writes a configuration once and then evaluates the function on every cycle, or between clock edges.

Top module: `mux_func_gen`

## Requirements
- R1: The leg index is `varIn[NumIn-1:1]` read as an unsigned binary number, with `varIn[NumIn-1]` most significant. `funcOut` equals the value of the leg at that index, and `varIn[0]` is the residual variable.
- R2: A leg whose code is 2'b00 drives constant 0.
- R3: A leg whose code is 2'b01 drives constant 1.
- R4: A leg whose code is 2'b10 drives the residual variable `varIn[0]`.
- R5: A leg whose code is 2'b11 drives the inverse of `varIn[0]`.
- R6: The code of leg k occupies bits [2k+1:2k] of the configuration. The configuration is loaded from `cfgWrData` on a rising clock edge when `cfgWrEn` is high and `rst` is low.
- R7: While `cfgWrEn` is low, clock edges leave the configuration unchanged and `cfgWrData` has no effect on `funcOut`.
- R8: A rising edge with `rst` high clears the configuration to all zeros, so `funcOut` is 0 for every input. `rst` takes priority over `cfgWrEn`.
- R9: `funcOut` follows changes on `varIn` within the same clock cycle, with no clock edge in between.
- R10: For any truth table of `NumIn` variables, there is a configuration under which `funcOut` matches that table on every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high clear of the configuration |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | 2*2^(NumIn-1) | New configuration, two bits per leg |
| varIn | input | NumIn | Function variables; bit 0 is the residual variable |
| funcOut | output | 1 | Function value |

## Verification
The bench builds the cell twice. The first build uses `NumIn = 4`, which gives eight legs and sixteen input rows. At that size, walking a single active leg across every index exposes any error in select ordering. Random truth tables are then checked exhaustively against a table-driven reference. The second build uses the minimum `NumIn = 2`, where all sixteen possible functions of two variables can be programmed and checked row by row, so every pairing of the two legs' codes is covered.

// File: rtl/fgen_pkg.sv
`timescale 1ns/1ps
package fgen_pkg;

  // Residue choice per selector leg
  typedef enum logic [1:0] {
    LEG_ZERO = 2'b00,
    LEG_ONE  = 2'b01,
    LEG_PASS = 2'b10,
    LEG_INV  = 2'b11
  } legSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearCfg;
    logic loadCfg;
  } cfgStrobe_t;

endpackage

// File: rtl/fgen_ctrl.sv
`timescale 1ns/1ps
module fgen_ctrl
  import fgen_pkg::*;
(
  input  logic       rst,
  input  logic       cfgWrEn,
  output cfgStrobe_t strobe
);

  // Reset wins over a write in the same cycle
  always_comb begin
    strobe.clearCfg = rst;
    strobe.loadCfg  = cfgWrEn & ~rst;
  end

endmodule

// File: rtl/fgen_leg.sv
`timescale 1ns/1ps
module fgen_leg
  import fgen_pkg::*;
(
  input  logic [1:0] code,
  input  logic       residual,
  output logic       legVal
);

  always_comb begin
    case (legSel_e'(code))
      LEG_ZERO: legVal = 1'b0;
      LEG_ONE:  legVal = 1'b1;
      LEG_PASS: legVal = residual;
      LEG_INV:  legVal = ~residual;
      default:  legVal = 1'b0;
    endcase
  end

endmodule

// File: rtl/fgen_datapath.sv
`timescale 1ns/1ps
module fgen_datapath
  import fgen_pkg::*;
#(
  parameter int NumIn = 4
) (
  input  logic                           clk,
  input  cfgStrobe_t                     strobe,
  input  logic [2*(2**(NumIn-1))-1:0]    cfgWrData,
  input  logic [NumIn-1:0]               varIn,
  output logic [2*(2**(NumIn-1))-1:0]    cfgQ,
  output logic                           funcOut
);

  localparam int SelW    = NumIn - 1;
  localparam int NumLegs = 2 ** SelW;

  logic [NumLegs-1:0] legVals;
  logic [SelW-1:0]    selIdx;

  // Configuration storage
  always_ff @(posedge clk) begin
    if (strobe.clearCfg) begin
      cfgQ <= '0;
    end else if (strobe.loadCfg) begin
      cfgQ <= cfgWrData;
    end
  end

  // One residue generator per leg
  for (genvar g = 0; g < NumLegs; g++) begin : g_leg
    fgen_leg u_leg (
      .code     (cfgQ[2*g +: 2]),
      .residual (varIn[0]),
      .legVal   (legVals[g])
    );
  end

  // Selection by the upper variables
  assign selIdx  = varIn[NumIn-1:1];
  assign funcOut = legVals[selIdx];

endmodule

// File: rtl/mux_func_gen.sv
`timescale 1ns/1ps
module mux_func_gen
  import fgen_pkg::*;
#(
  parameter int NumIn = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfgWrEn,
  input  logic [2*(2**(NumIn-1))-1:0]    cfgWrData,
  input  logic [NumIn-1:0]               varIn,
  output logic                           funcOut
);

  localparam int CfgW = 2 * (2 ** (NumIn - 1));

  cfgStrobe_t      strobe;
  logic [CfgW-1:0] cfgQ;

  fgen_ctrl u_ctrl (
    .rst     (rst),
    .cfgWrEn (cfgWrEn),
    .strobe  (strobe)
  );

  fgen_datapath #(.NumIn(NumIn)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .cfgWrData (cfgWrData),
    .varIn     (varIn),
    .cfgQ      (cfgQ),
    .funcOut   (funcOut)
  );

endmodule

// File: rtl/mux_func_gen_chk.sv
`timescale 1ns/1ps
module mux_func_gen_chk #(
  parameter int NumIn = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfgWrEn,
  input logic [2*(2**(NumIn-1))-1:0] cfgWrData,
  input logic [NumIn-1:0]            varIn,
  input logic [2*(2**(NumIn-1))-1:0] cfgQ,
  input logic                        funcOut
);

  localparam int SelW = NumIn - 1;

  logic [SelW-1:0] selIdx;
  logic [1:0]      curCode;

  assign selIdx  = varIn[NumIn-1:1];
  assign curCode = cfgQ[{selIdx, 1'b0} +: 2];

  // R8: configuration is zero right after reset drops
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfgQ == '0));

  // R6: write loads the data presented at the edge
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> (cfgQ == $past(cfgWrData)));

  // R7: no write, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cfgWrEn |=> $stable(cfgQ));

  // R2
  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (curCode == 2'b00) |-> !funcOut);

  // R3
  p_one_r3: assert property (@(posedge clk) disable iff (rst)
    (curCode == 2'b01) |-> funcOut);

  // R4
  p_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (curCode == 2'b10) |-> (funcOut == varIn[0]));

  // R5
  p_inv_r5: assert property (@(posedge clk) disable iff (rst)
    (curCode == 2'b11) |-> (funcOut != varIn[0]));

endmodule

bind mux_func_gen mux_func_gen_chk #(.NumIn(NumIn)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .varIn     (varIn),
  .cfgQ      (cfgQ),
  .funcOut   (funcOut)
);

// File: tb/test_mux_func_gen.sv
`timescale 1ns/1ps
module test_mux_func_gen;

  localparam int N     = 4;
  localparam int Legs  = 2 ** (N - 1);
  localparam int CfgW  = 2 * Legs;
  localparam int Rows  = 2 ** N;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic            cfgWrEn = 1'b0;
  logic [CfgW-1:0] cfgWrData = '0;
  logic [N-1:0]    varIn = '0;
  logic            funcOut;

  logic       sWrEn = 1'b0;
  logic [3:0] sWrData = '0;
  logic [1:0] sVarIn = '0;
  logic       sOut;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_func_gen #(.NumIn(N)) i_mux_func_gen (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .varIn(varIn), .funcOut(funcOut)
  );

  mux_func_gen #(.NumIn(2)) i_mux_func_gen_n2 (
    .clk(clk), .rst(rst), .cfgWrEn(sWrEn), .cfgWrData(sWrData),
    .varIn(sVarIn), .funcOut(sOut)
  );

  task automatic check(input string req, input logic act, input logic exp, input int row);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s row %0d: actual %b expected %b", req, row, act, exp);
    end
  endtask

  function automatic logic codeValue(input logic [1:0] c, input logic r);
    case (c)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return r;
      default: return ~r;
    endcase
  endfunction

  // Code that reproduces row pair (value at r=0, value at r=1)
  function automatic logic [1:0] codeFor(input logic f0, input logic f1);
    case ({f0, f1})
      2'b00: return 2'b00;
      2'b11: return 2'b01;
      2'b01: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic writeCfg(input logic [CfgW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sweepConst(input string req, input logic exp);
    for (int r = 0; r < Rows; r++) begin
      varIn = N'(r); #0.5;
      check(req, funcOut, exp, r);
    end
  endtask

  // R8: reset clears, and wins over a simultaneous write
  task automatic testReset();
    sweepConst("R8 reset state", 1'b0);
    @(negedge clk);
    rst = 1'b1; cfgWrEn = 1'b1; cfgWrData = '1;
    @(negedge clk);
    rst = 1'b0; cfgWrEn = 1'b0;
    sweepConst("R8 reset priority", 1'b0);
    writeCfg({Legs{2'b01}});
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    sweepConst("R8 clear after load", 1'b0);
  endtask

  // R2..R5: all legs carry the same code
  task automatic testCodes();
    string tags[4] = '{"R2 code 00", "R3 code 01", "R4 code 10", "R5 code 11"};
    for (int c = 0; c < 4; c++) begin
      writeCfg({Legs{2'(c)}});
      for (int r = 0; r < Rows; r++) begin
        varIn = N'(r); #0.5;
        check(tags[c], funcOut, codeValue(2'(c), r[0]), r);
      end
    end
  endtask

  // R1, R6: a single active leg walks through every index
  task automatic testIndex();
    for (int k = 0; k < Legs; k++) begin
      logic [CfgW-1:0] d = '0;
      d[2*k +: 2] = 2'b01;
      writeCfg(d);
      for (int r = 0; r < Rows; r++) begin
        varIn = N'(r); #0.5;
        check("R1 R6 leg index", funcOut, ((r >> 1) == k), r);
      end
    end
  endtask

  // R7: write data ignored without enable
  task automatic testHold();
    logic [CfgW-1:0] a = CfgW'(32'h0000_9C63);
    writeCfg(a);
    @(negedge clk);
    cfgWrData = ~a;
    repeat (3) @(negedge clk);
    for (int r = 0; r < Rows; r++) begin
      varIn = N'(r); #0.5;
      check("R7 hold", funcOut, codeValue(a[2*(r>>1) +: 2], r[0]), r);
    end
    cfgWrData = '0;
  endtask

  // R9: output follows inputs between edges
  task automatic testComb();
    writeCfg({Legs{2'b10}});
    @(posedge clk); #0.3;
    varIn = 4'b0001; #0.3;
    check("R9 comb rise", funcOut, 1'b1, 1);
    varIn = 4'b0110; #0.3;
    check("R9 comb fall", funcOut, 1'b0, 6);
  endtask

  // R10: random truth tables, exhaustive rows
  task automatic testRandom();
    for (int t = 0; t < 24; t++) begin
      logic [Rows-1:0] tt = Rows'($urandom());
      logic [CfgW-1:0] d;
      for (int k = 0; k < Legs; k++) d[2*k +: 2] = codeFor(tt[2*k], tt[2*k+1]);
      writeCfg(d);
      for (int r = 0; r < Rows; r++) begin
        varIn = N'(r); #0.5;
        check("R10 random table", funcOut, tt[r], r);
      end
    end
  endtask

  // R10 at NumIn=2: every function of two variables
  task automatic testSmall();
    for (int t = 0; t < 16; t++) begin
      logic [3:0] tt = 4'(t);
      @(negedge clk);
      sWrEn = 1'b1;
      sWrData = {codeFor(tt[2], tt[3]), codeFor(tt[0], tt[1])};
      @(negedge clk);
      sWrEn = 1'b0;
      for (int r = 0; r < 4; r++) begin
        sVarIn = 2'(r); #0.5;
        check("R10 two-variable", sOut, tt[r], r);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    testReset();
    testCodes();
    testIndex();
    testHold();
    testComb();
    testRandom();
    testSmall();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule